// File: doc/BRIEF.md
# User Mode Privileged-Instruction Trap

This block watches the instruction stream of a time-shared 12-bit minicomputer and raises a single trap flag whenever a user program attempts an instruction reserved for the executive. The privileged instructions are all I/O transfer words, the halt instruction, and the two instructions that read the front-panel switches. Each of them traps only when the user-mode flag and the time-sharing enable are both 1 and the instruction is presented with a one-cycle execute strobe.

The flag is a single registered bit that holds its value until something clears it. Three events clear it: the front-panel clear input, and two flag-clearing I/O instructions. Those two instructions clear the flag only when they really execute, that is, outside trapped user mode. Inside trapped user mode they are ordinary I/O words and set the trap instead. The interrupt sequencer that acts on the flag lives outside this block.

Top module: `user_trap_ctl`

## Requirements
- R1: Asynchronous reset (rst_ni low) forces trap_o to 0 at once, and trap_o stays 0 until a set condition occurs.
- R2: With exec_i=1, user_mode_i=1 and ts_enable_i=1, any word whose bits [11:9] are 3'b110 (octal 6xxx, I/O transfer) sets trap_o on the next clock edge.
- R3: Under the same qualifiers, a halt instruction sets trap_o on the next edge. A halt is an operate word of the second group: bits [11:9]=3'b111, bit 8=1, bit 0=0, and bit 1=1 (for example octal 7402).
- R4: Under the same qualifiers, a switch-read instruction of the second operate group (bit 2=1) sets trap_o on the next edge. This covers OR-with-switches (octal 7404) and load-from-switches (octal 7604).
- R5: A privileged word does not set trap_o when exec_i=0, when user_mode_i=0, or when ts_enable_i=0.
- R6: panel_clear_i=1 at an edge makes trap_o 0 after that edge. It takes priority over a set condition in the same cycle.
- R7: Clear-all-flags (octal 6007) with exec_i=1 clears trap_o on the next edge when user_mode_i and ts_enable_i are not both 1. When both are 1, the word sets trap_o.
- R8: Clear-user-interrupt (octal 6204) with exec_i=1 clears trap_o on the next edge when user_mode_i and ts_enable_i are not both 1. When both are 1, the word sets trap_o.
- R9: In any cycle with no set and no clear condition, trap_o keeps its value. This includes non-privileged words such as memory-reference words (octal 0xxx to 5xxx), first-group operate words (bit 8=0), and third-group operate words (bits [11:9]=3'b111, bit 8=1, bit 0=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 12 | Instruction word being executed (bit 11 is the most significant bit) |
| exec_i | input | 1 | One-cycle strobe marking that insn_i executes in this cycle |
| user_mode_i | input | 1 | The user-mode flag |
| ts_enable_i | input | 1 | Time-sharing enable |
| panel_clear_i | input | 1 | Front-panel clear, synchronous |
| trap_o | output | 1 | Registered trap flag |

## Verification
Every result of this block appears exactly one clock edge after the cycle in which its stimulus is presented. A set, a clear or a hold decided in cycle n is visible on trap_o after edge n+1. The only exception is reset, which acts at once without a clock. The bench drives each stimulus on the falling edge and samples trap_o shortly after the following rising edge. At that point it compares trap_o with a reference flag that a bench function advances from the same inputs. The reset check is sampled while rst_ni is still low.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned WORD_W = 12;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [2:0] OPC_IOT = 3'b110;
  localparam logic [2:0] OPC_OPR = 3'b111;
  localparam word_t      W_CLR_ALL  = 12'o6007;
  localparam word_t      W_CLR_UINT = 12'o6204;

  // Bit positions (bit 11 = MSB)
  localparam int unsigned B_GRP  = 8;
  localparam int unsigned B_G3   = 0;
  localparam int unsigned B_HALT = 1;
  localparam int unsigned B_SWR  = 2;

  typedef struct packed {
    logic io_xfer;
    logic halt;
    logic sw_read;
    logic clr_all;
    logic clr_uint;
  } dec_t;
endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t insn_i,
  output dec_t  dec_o
);
  localparam int unsigned TOP = WORD_W - 1;

  logic [2:0] opc;
  logic       grp2;

  assign opc  = insn_i[TOP -: 3];
  assign grp2 = (opc == OPC_OPR) && insn_i[B_GRP] && !insn_i[B_G3];

  always_comb begin
    dec_o          = '0;
    dec_o.io_xfer  = (opc == OPC_IOT);
    dec_o.halt     = grp2 && insn_i[B_HALT];
    dec_o.sw_read  = grp2 && insn_i[B_SWR];
    dec_o.clr_all  = (insn_i == W_CLR_ALL);
    dec_o.clr_uint = (insn_i == W_CLR_UINT);
  end

  // Flag-clearing words are I/O words; operate decodes never overlap I/O (R7, R8)
  assert_clr_is_io_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_o.clr_all || dec_o.clr_uint) |-> dec_o.io_xfer);
  assert_opr_not_io_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_o.halt || dec_o.sw_read) |-> !dec_o.io_xfer);
endmodule

// File: rtl/trap_flag_reg.sv
module trap_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_clr_i,
  input  logic set_i,
  input  logic soft_clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (hard_clr_i)      flag_d = 1'b0;
    else if (set_i)      flag_d = 1'b1;
    else if (soft_clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_hard_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_clr_i |=> !flag_o);
  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !hard_clr_i) |=> flag_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hard_clr_i && !set_i && !soft_clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/user_trap_ctl.sv
module user_trap_ctl
  import trap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] insn_i,
  input  logic              exec_i,
  input  logic              user_mode_i,
  input  logic              ts_enable_i,
  input  logic              panel_clear_i,
  output logic              trap_o
);
  dec_t dec;
  logic guarded, priv, set, soft_clr;

  trap_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  assign guarded  = user_mode_i && ts_enable_i;
  assign priv     = dec.io_xfer || dec.halt || dec.sw_read;
  assign set      = exec_i && guarded && priv;
  // Clearing words only act when really executed (not trapped)
  assign soft_clr = exec_i && !guarded && (dec.clr_all || dec.clr_uint);

  trap_flag_reg u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hard_clr_i (panel_clear_i),
    .set_i      (set),
    .soft_clr_i (soft_clr),
    .flag_o     (trap_o)
  );

  assert_io_trap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && user_mode_i && ts_enable_i && !panel_clear_i
     && insn_i[11:9] == 3'b110) |=> trap_o);
  assert_halt_trap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && user_mode_i && ts_enable_i && !panel_clear_i
     && insn_i[11:8] == 4'b1111 && !insn_i[0] && insn_i[1]) |=> trap_o);
  assert_swr_trap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && user_mode_i && ts_enable_i && !panel_clear_i
     && insn_i[11:8] == 4'b1111 && !insn_i[0] && insn_i[2]) |=> trap_o);
  assert_no_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_o && !(exec_i && user_mode_i && ts_enable_i)) |=> !trap_o);
  assert_caf_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && insn_i == 12'o6007 && !(user_mode_i && ts_enable_i)) |=> !trap_o);
  assert_cint_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && insn_i == 12'o6204 && !(user_mode_i && ts_enable_i)) |=> !trap_o);
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_i && !panel_clear_i) |=> $stable(trap_o));
endmodule

// File: tb/tb_user_trap_ctl.sv
module tb_user_trap_ctl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] insn_i = '0;
  logic        exec_i = 1'b0, user_mode_i = 1'b0, ts_enable_i = 1'b0, panel_clear_i = 1'b0;
  logic        trap_o;

  int checks = 0, failures = 0;
  logic exp_flag = 1'b0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i; // 125 MHz

  user_trap_ctl dut (.*);

  function automatic logic is_priv(input logic [11:0] w);
    logic g2;
    g2 = (w[11:9] == 3'b111) && w[8] && !w[0];
    return (w[11:9] == 3'b110) || (g2 && (w[1] || w[2]));
  endfunction

  function automatic logic next_flag(input logic cur, input logic [11:0] w,
      input logic ex, input logic um, input logic te, input logic pc);
    logic gd;
    gd = um && te;
    if (pc) return 1'b0;
    if (ex && gd && is_priv(w)) return 1'b1;
    if (ex && !gd && (w == 12'o6007 || w == 12'o6204)) return 1'b0;
    return cur;
  endfunction

  task automatic check(input string req, input logic exp);
    checks++;
    if (trap_o !== exp) begin
      failures++;
      $display("FAIL %s insn=%o trap_o=%b expected=%b", req, insn_i, trap_o, exp);
    end
  endtask

  task automatic step(input logic [11:0] w, input logic ex, input logic um,
      input logic te, input logic pc, input string req);
    @(negedge clk_i);
    insn_i = w; exec_i = ex; user_mode_i = um; ts_enable_i = te; panel_clear_i = pc;
    exp_flag = next_flag(exp_flag, w, ex, um, te, pc);
    @(posedge clk_i); #1;
    check(req, exp_flag);
  endtask

  task automatic force_set();
    step(12'o6031, 1, 1, 1, 0, "R2 preset");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [11:0] srcs [4];
    srcs[0] = 12'o6031; srcs[1] = 12'o7402; srcs[2] = 12'o7404; srcs[3] = 12'o7604;
    void'($urandom(32'd4242));
    #3; checks++;
    if (trap_o !== 1'b0) begin failures++; $display("FAIL R1 trap_o=%b expected=0", trap_o); end
    #20 rst_ni = 1'b1;
    step(12'o0000, 0, 0, 0, 0, "R1 after reset");

    // Each trap source against all qualifier combinations (R2, R3, R4, R5)
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        step(12'o7000, 0, 0, 0, 1, "R6 preclear");
        step(srcs[s], 1, c[1], c[0], 0, (c == 3) ? (s == 0 ? "R2" : s == 1 ? "R3" : "R4") : "R5");
      end
    end
    step(12'o7000, 0, 0, 0, 1, "R6");
    step(12'o6031, 0, 1, 1, 0, "R5 no exec");

    // Clears
    force_set(); step(12'o0000, 0, 1, 1, 1, "R6 panel");
    step(12'o6031, 1, 1, 1, 1, "R6 beats set");
    force_set(); step(12'o6007, 1, 0, 1, 0, "R7 clear");
    force_set(); step(12'o6007, 1, 1, 0, 0, "R7 clear ts off");
    step(12'o6007, 1, 1, 1, 0, "R7 traps in user");
    force_set(); step(12'o6204, 1, 1, 0, 0, "R8 clear");
    step(12'o6204, 1, 1, 1, 0, "R8 traps in user");
    step(12'o6204, 0, 0, 0, 0, "R8 no exec holds");

    // Hold on non-privileged words
    step(12'o7300, 1, 1, 1, 0, "R9 group1");
    step(12'o7401, 1, 1, 1, 0, "R9 group3");
    step(12'o1234, 1, 1, 1, 0, "R9 memref");
    step(12'o5777, 1, 0, 0, 0, "R9 memref exec");

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] w;
      int k;
      k = $urandom_range(0, 7);
      case (k)
        0: w = 12'o6007;
        1: w = 12'o6204;
        2: w = 12'o7402;
        3: w = 12'o7604;
        default: w = 12'($urandom);
      endcase
      step(w, 1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
           1'($urandom_range(0, 15) == 0), "R9 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule